// File: doc/BRIEF.md
# Lane-Scrambled Parity Memory

This block sits between a byte-wide requester and a 9-bit-wide storage array and protects every stored byte with one parity bit. The parity bit does not have a fixed home. After reset the block derives a secret 4-bit setting from a seeded pseudo-random generator and keeps it until the next reset. That setting decides which physical lane carries the parity bit and whether the parity sense is even or odd. A storage device that does not keep the parity bit, and instead makes one up from the data it returns, therefore has to guess both the lane and the sense. Any wrong guess of the sense shows up as a parity fault on every read.

Writes are scrambled on the way into the internal array and reads are unscrambled on the way out. Both paths are pure steering logic, so a read still returns one cycle after it is accepted. Each read reports a per-read parity error. A sticky fault flag collects those errors until the requester clears it. Two test controls allow the block to be checked in isolation. One flips a chosen physical lane while a byte is written. The other replaces the stored lane contents at read time with a parity bit made up on the fly, as a counterfeit device would do.

Top module: `lane_parity_mem`

## Requirements
- R1: `cfg_valid` and `req_ready` are low during reset and after it, and both go high exactly WARMUP rising edges after `rst_n` is sampled high. No request is accepted while `req_ready` is low.
- R2: The 16-bit generator loads `seed` during reset, or the value 1 when `seed` is zero. It then advances once per edge as s <= {s[14:0], s[15]^s[13]^s[12]^s[10]}. The secret setting is bits [3:0] of the state after WARMUP advances, and it stays fixed until the next reset.
- R3: Bits [3:1] of the setting give the parity lane P (0 to 7). Physical lane P carries the parity bit, physical lane 8 carries data bit P, and every other data bit i stays on lane i.
- R4: Bit [0] of the setting is the sense. With 0, the XOR of the eight data bits and the parity bit is 0 (even). With 1, that XOR is 1 (odd).
- R5: A read accepted at an edge gives `rvalid` high, with `rdata`, in the cycle right after that edge. A write never raises `rvalid`. A byte written without injection reads back unchanged with `parity_err` low.
- R6: `inj_en` together with an accepted write inverts physical lane `inj_lane` (0 to 8) of the stored word. `inj_lane` values 9 to 15 invert nothing. On read-back, a flip on lane P leaves the data intact, a flip on lane 8 inverts data bit P, and a flip on any other lane L inverts data bit L. In each of these three cases the read reports a parity error.
- R7: `parity_err` is high only in a cycle where `rvalid` is high and the recovered data and parity bit break the configured sense.
- R8: `fault_status` goes high in the cycle after any `parity_err` pulse. It stays high until a cycle in which `fault_clr` is high and `parity_err` is low, and it is low in the cycle after that one. If both are high in the same cycle, setting wins.
- R9: When `fake_en` is high with a read request, lane `fake_lane` (0 to 8) of the read word is replaced by the XOR of the other eight lanes XOR `fake_odd`. `fake_lane` values 9 to 15 replace nothing. Such a read flags a parity error exactly when `fake_odd` differs from the configured sense. When both the lane and the sense match the setting, the written byte comes back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| seed | input | 16 | Generator seed, sampled while in reset |
| cfg_valid | output | 1 | Secret setting has been latched |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block accepts requests |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 8 | Write byte |
| rvalid | output | 1 | Read response present |
| rdata | output | 8 | Read byte |
| parity_err | output | 1 | Parity fault on this response |
| fault_status | output | 1 | Sticky fault flag |
| fault_clr | input | 1 | Clears the sticky fault flag |
| inj_en | input | 1 | Invert one physical lane during this write |
| inj_lane | input | 4 | Physical lane to invert |
| fake_en | input | 1 | Read through the counterfeit-parity model |
| fake_lane | input | 4 | Lane the counterfeit model treats as parity |
| fake_odd | input | 1 | Sense the counterfeit model assumes |

## Verification
The setting is due on the WARMUP-th edge after reset release. A read's data and parity flag are due one edge after acceptance, and the sticky flag one edge after a flagged response. The bench keeps a behavioural model that moves one cycle per call. Each call drives the inputs just after a falling edge, updates the model as the next rising edge would, and compares every output at the following falling edge. Each result is therefore compared in the one cycle it is due, including back-to-back reads and a clear that meets an error in the same cycle.

// File: rtl/lsp_pkg.sv
// Shared widths, types and the generator step function for the
// lane-scrambled parity memory. Assumes one parity bit per byte.
package lsp_pkg;
    localparam int DBITS      = 8;                  // data bits per word
    localparam int LANES      = DBITS + 1;          // physical lanes
    localparam int LANE_IDX_W = $clog2(LANES);      // lane selector width
    localparam int PLANE_W    = $clog2(DBITS);      // parity lane field width
    localparam int LFSR_W     = 16;                 // generator width
    localparam int CFG_W      = PLANE_W + 1;        // secret setting width

    typedef logic [DBITS-1:0] byte_t;
    typedef logic [LANES-1:0] phys_t;

    // Secret setting: parity lane in the upper bits, sense in bit 0.
    typedef struct packed {
        logic [PLANE_W-1:0] plane;
        logic               odd;
    } cfg_t;

    // One step of the maximal-length 16-bit generator.
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction
endpackage

// File: rtl/lsp_cfg_gen.sv
// Generates the secret lane/sense setting. The generator loads the seed
// while reset is held, advances WARMUP times afterwards, then latches its
// low bits and stops. Assumes WARMUP >= 1.
module lsp_cfg_gen
    import lsp_pkg::*;
#(
    parameter int WARMUP = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LFSR_W-1:0] seed,
    output cfg_t              cfg,
    output logic              cfg_valid
);
    localparam int CNT_W = $clog2(WARMUP + 1);

    logic [LFSR_W-1:0] state;
    logic [LFSR_W-1:0] state_nxt;
    logic [CNT_W-1:0]  cnt;

    assign state_nxt = lfsr_step(state);

    // Seed load, warm-up stepping and the one-time latch of the setting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= (seed == '0) ? LFSR_W'(1) : seed;
            cnt       <= '0;
            cfg_valid <= 1'b0;
            cfg       <= '0;
        end else if (!cfg_valid) begin
            state <= state_nxt;
            cnt   <= cnt + CNT_W'(1);
            if (cnt == CNT_W'(WARMUP - 1)) begin
                cfg_valid <= 1'b1;
                cfg       <= cfg_t'(state_nxt[CFG_W-1:0]);
            end
        end
    end

    // Once latched, the setting never changes before the next reset.
    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> (cfg_valid && $stable(cfg)));
endmodule

// File: rtl/lsp_lane_map.sv
// Steering between logical bytes and physical lanes. The write path adds
// parity and swaps it with data bit P onto lane 8. The read path undoes the
// swap and tests the sense. Both paths are purely combinational.
module lsp_lane_map
    import lsp_pkg::*;
(
    input  cfg_t  cfg,
    input  byte_t wdata,
    output phys_t wphys,
    input  phys_t rphys,
    output byte_t rdata,
    output logic  mismatch
);
    logic par;

    // Parity bit that meets the configured sense.
    assign par = (^wdata) ^ cfg.odd;

    for (genvar i = 0; i < DBITS; i++) begin : g_lane
        // Write: lane P takes parity, others keep their data bit.
        assign wphys[i] = (cfg.plane == PLANE_W'(i)) ? par : wdata[i];
        // Read: data bit P comes back from lane 8.
        assign rdata[i] = (cfg.plane == PLANE_W'(i)) ? rphys[DBITS] : rphys[i];
    end

    // Displaced data bit travels on the extra lane.
    assign wphys[DBITS] = wdata[cfg.plane];

    // Recovered byte and parity lane must XOR to the sense.
    assign mismatch = ((^rdata) ^ rphys[cfg.plane]) != cfg.odd;
endmodule

// File: rtl/lsp_store.sv
// Internal 9-bit storage with a registered read port. One access per
// cycle; the contents are not reset.
module lsp_store
    import lsp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  phys_t             wphys,
    output phys_t             rphys,
    output logic              rvalid
);
    localparam int DEPTH = 1 << ADDR_W;

    phys_t mem [DEPTH];

    // Array write port.
    always_ff @(posedge clk) begin
        if (wr_en) mem[addr] <= wphys;
    end

    // Registered read word and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rphys  <= '0;
        end else begin
            rvalid <= rd_en;
            if (rd_en) rphys <= mem[addr];
        end
    end
endmodule

// File: rtl/lsp_fake_parity.sv
// Test model of a counterfeit device. It drops the lane it believes holds
// parity and regenerates that lane from the other eight with its own
// assumed sense. Lane selectors above 8 leave the word untouched.
module lsp_fake_parity
    import lsp_pkg::*;
(
    input  logic                  en,
    input  logic [LANE_IDX_W-1:0] lane,
    input  logic                  odd,
    input  phys_t                 pin,
    output phys_t                 pout
);
    logic all_x;

    // XOR over all nine lanes; removing one lane is one more XOR.
    assign all_x = ^pin;

    for (genvar l = 0; l < LANES; l++) begin : g_sub
        assign pout[l] = (en && (lane == LANE_IDX_W'(l))) ? (all_x ^ pin[l] ^ odd) : pin[l];
    end
endmodule

// File: rtl/lane_parity_mem.sv
// Top level of the lane-scrambled parity memory. Accepts one request per
// cycle once the secret setting exists and returns read data one cycle
// after acceptance. Keeps a sticky fault flag. Assumes inputs are
// synchronous to clk.
module lane_parity_mem
    import lsp_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int WARMUP = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LFSR_W-1:0]     seed,
    output logic                  cfg_valid,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_we,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DBITS-1:0]      req_wdata,
    output logic                  rvalid,
    output logic [DBITS-1:0]      rdata,
    output logic                  parity_err,
    output logic                  fault_status,
    input  logic                  fault_clr,
    input  logic                  inj_en,
    input  logic [LANE_IDX_W-1:0] inj_lane,
    input  logic                  fake_en,
    input  logic [LANE_IDX_W-1:0] fake_lane,
    input  logic                  fake_odd
);
    cfg_t                  cfg;
    logic                  accept;
    logic                  wr_acc;
    logic                  rd_acc;
    phys_t                 scr_phys;
    phys_t                 inj_mask;
    phys_t                 wr_phys;
    phys_t                 raw_phys;
    phys_t                 seen_phys;
    logic                  mismatch;
    logic                  fake_en_q;
    logic                  fake_odd_q;
    logic [LANE_IDX_W-1:0] fake_lane_q;

    lsp_cfg_gen #(.WARMUP(WARMUP)) i_cfg_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .seed      (seed),
        .cfg       (cfg),
        .cfg_valid (cfg_valid)
    );

    assign req_ready = cfg_valid;
    assign accept    = req_valid && req_ready;
    assign wr_acc    = accept && req_we;
    assign rd_acc    = accept && !req_we;

    // Lane inversion mask for fault injection on writes.
    for (genvar l = 0; l < LANES; l++) begin : g_inj
        assign inj_mask[l] = inj_en && (inj_lane == LANE_IDX_W'(l));
    end

    assign wr_phys = scr_phys ^ inj_mask;

    lsp_store #(.ADDR_W(ADDR_W)) i_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_acc),
        .rd_en  (rd_acc),
        .addr   (req_addr),
        .wphys  (wr_phys),
        .rphys  (raw_phys),
        .rvalid (rvalid)
    );

    // Counterfeit-model controls travel with their read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fake_en_q   <= 1'b0;
            fake_odd_q  <= 1'b0;
            fake_lane_q <= '0;
        end else if (rd_acc) begin
            fake_en_q   <= fake_en;
            fake_odd_q  <= fake_odd;
            fake_lane_q <= fake_lane;
        end
    end

    lsp_fake_parity i_fake (
        .en   (fake_en_q),
        .lane (fake_lane_q),
        .odd  (fake_odd_q),
        .pin  (raw_phys),
        .pout (seen_phys)
    );

    lsp_lane_map i_lane_map (
        .cfg      (cfg),
        .wdata    (req_wdata),
        .wphys    (scr_phys),
        .rphys    (seen_phys),
        .rdata    (rdata),
        .mismatch (mismatch)
    );

    assign parity_err = rvalid && mismatch;

    // Sticky fault flag; a new error outranks a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          fault_status <= 1'b0;
        else if (parity_err) fault_status <= 1'b1;
        else if (fault_clr)  fault_status <= 1'b0;
    end

    // An accepted read answers on the next cycle.
    p_read_answers_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_we) |=> rvalid);
    // Without an accepted read there is no response.
    p_no_spurious_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready && !req_we) |=> !rvalid);
    // Nothing is accepted before the setting exists.
    p_ready_after_cfg_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |=> !$past(rvalid) || cfg_valid);
    // A flagged response sets the sticky flag.
    p_fault_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        parity_err |=> fault_status);
    // Sticky flag holds without a clear.
    p_fault_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_status && !fault_clr) |=> fault_status);
    // A clear without a competing error drops the flag.
    p_fault_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_clr && !parity_err) |=> !fault_status);
endmodule

// File: tb/test_lane_parity_mem.sv
// Self-checking bench: a behavioural model advanced once per cycle and
// compared with the outputs at every falling edge. Clock period 20 units
// (50 MHz at 1 ns).
module test_lane_parity_mem;
    localparam int ADDR_W = 8;
    localparam int WARMUP = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       seed = 16'h0;
    logic              cfg_valid;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_we = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [7:0]        req_wdata = '0;
    logic              rvalid;
    logic [7:0]        rdata;
    logic              parity_err;
    logic              fault_status;
    logic              fault_clr = 1'b0;
    logic              inj_en = 1'b0;
    logic [3:0]        inj_lane = '0;
    logic              fake_en = 1'b0;
    logic [3:0]        fake_lane = '0;
    logic              fake_odd = 1'b0;

    always #10 clk = ~clk;

    lane_parity_mem #(.ADDR_W(ADDR_W), .WARMUP(WARMUP)) i_lane_parity_mem (
        .clk(clk), .rst_n(rst_n), .seed(seed), .cfg_valid(cfg_valid),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .rvalid(rvalid),
        .rdata(rdata), .parity_err(parity_err), .fault_status(fault_status),
        .fault_clr(fault_clr), .inj_en(inj_en), .inj_lane(inj_lane),
        .fake_en(fake_en), .fake_lane(fake_lane), .fake_odd(fake_odd)
    );

    int    n_checks = 0;
    int    n_err = 0;
    bit    done = 0;
    string cur_req = "R1";

    // Model state.
    logic [3:0] m_cfg;
    bit         m_valid;
    int         m_cnt;
    logic [8:0] mphys [256];
    bit         e_rvalid, e_err, e_fs;
    logic [7:0] e_rdata;

    // R2: setting derived from the seed.
    function automatic logic [3:0] cfg_of(input logic [15:0] sd);
        logic [15:0] s;
        s = (sd == 16'h0) ? 16'h1 : sd;
        for (int k = 0; k < WARMUP; k++) s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
        return s[3:0];
    endfunction

    // R3/R4: physical word for a byte.
    function automatic logic [8:0] m_scr(input logic [7:0] d, input logic [3:0] c);
        int p;
        logic [8:0] w;
        p = int'(c[3:1]);
        w = {1'b0, d};
        w[8] = d[p];
        w[p] = (^d) ^ c[0];
        return w;
    endfunction

    // R3/R4: {error, byte} recovered from a physical word.
    function automatic logic [8:0] m_dscr(input logic [8:0] w, input logic [3:0] c);
        int p;
        logic [7:0] d;
        logic bad;
        p = int'(c[3:1]);
        d = w[7:0];
        d[p] = w[8];
        bad = ((^d) ^ w[p]) != c[0];
        return {bad, d};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One clock cycle: drive, advance model, compare at the next falling edge.
    task automatic cyc(input bit v, input bit we, input logic [7:0] a, input logic [7:0] wd,
                       input bit ie, input logic [3:0] il, input bit fe, input logic [3:0] fl,
                       input bit fo, input bit clr);
        bit acc;
        logic [8:0] w;
        logic [8:0] r;
        logic x;
        req_valid = v; req_we = we; req_addr = a; req_wdata = wd;
        inj_en = ie; inj_lane = il; fake_en = fe; fake_lane = fl; fake_odd = fo;
        fault_clr = clr;
        #1;
        chk("R1", "req_ready", req_ready, m_valid);
        acc = v && m_valid;
        e_fs = (e_rvalid && e_err) ? 1'b1 : (clr ? 1'b0 : e_fs);
        if (acc && !we) begin
            w = mphys[a];
            if (fe && fl <= 4'd8) begin
                x = fo;
                for (int k = 0; k < 9; k++) if (k != int'(fl)) x = x ^ w[k];
                w[fl] = x;
            end
            r = m_dscr(w, m_cfg);
            e_err = r[8];
            e_rdata = r[7:0];
            e_rvalid = 1'b1;
        end else begin
            e_rvalid = 1'b0;
            e_err = 1'b0;
        end
        if (acc && we) begin
            w = m_scr(wd, m_cfg);
            if (ie && il <= 4'd8) w[il] = ~w[il];
            mphys[a] = w;
        end
        if (!m_valid) begin
            m_cnt++;
            if (m_cnt == WARMUP) m_valid = 1'b1;
        end
        @(negedge clk);
        chk("R1", "cfg_valid", cfg_valid, m_valid);
        chk("R5", "rvalid", rvalid, e_rvalid);
        if (e_rvalid) begin
            chk(cur_req, "rdata", rdata, e_rdata);
            chk(cur_req, "parity_err", parity_err, e_err);
        end else begin
            chk("R7", "parity_err without response", parity_err, 1'b0);
        end
        chk("R8", "fault_status", fault_status, e_fs);
    endtask

    task automatic idle(input bit clr);
        cyc(0, 0, 8'h0, 8'h0, 0, 4'h0, 0, 4'h0, 0, clr);
    endtask
    task automatic wr(input logic [7:0] a, input logic [7:0] d, input bit ie, input logic [3:0] il);
        cyc(1, 1, a, d, ie, il, 0, 4'h0, 0, 0);
    endtask
    task automatic rd(input logic [7:0] a, input bit fe, input logic [3:0] fl, input bit fo);
        cyc(1, 0, a, 8'h0, 0, 4'h0, fe, fl, fo, 0);
    endtask

    task automatic do_reset(input logic [15:0] sd);
        rst_n = 1'b0; seed = sd; req_valid = 1'b0; fault_clr = 1'b0;
        inj_en = 1'b0; fake_en = 1'b0;
        repeat (3) @(negedge clk);
        m_cfg = cfg_of(sd); m_valid = 0; m_cnt = 0;
        e_rvalid = 0; e_err = 0; e_fs = 0;
        chk("R1", "cfg_valid in reset", cfg_valid, 1'b0);
        chk("R1", "req_ready in reset", req_ready, 1'b0);
        chk("R5", "rvalid in reset", rvalid, 1'b0);
        chk("R8", "fault_status in reset", fault_status, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic run_cfg(input logic [15:0] sd);
        logic [7:0] pat;
        pat = 8'h5A ^ sd[7:0];
        do_reset(sd);
        cur_req = "R1";
        for (int k = 0; k < 4; k++) rd(8'h10, 0, 4'h0, 0);   // refused while not ready
        while (!m_valid) idle(0);
        cur_req = "R2 R4 R5";
        wr(8'h10, pat, 0, 4'h0);
        rd(8'h10, 0, 4'h0, 0);
        wr(8'h11, ~pat, 0, 4'h0);
        rd(8'h10, 0, 4'h0, 0);
        rd(8'h11, 0, 4'h0, 0);
        idle(0);
        cur_req = "R3 R6";
        for (int l = 0; l < 9; l++) wr(8'h20 + 8'(l), pat ^ 8'(l * 37), 1, 4'(l));
        for (int l = 0; l < 9; l++) rd(8'h20 + 8'(l), 0, 4'h0, 0);
        idle(0);
        cur_req = "R6";
        wr(8'h30, pat, 1, 4'd9);
        wr(8'h31, ~pat, 1, 4'd15);
        rd(8'h30, 0, 4'h0, 0);
        rd(8'h31, 0, 4'h0, 0);
        idle(0);
        cur_req = "R8";
        idle(1);                    // clear with no error pending
        idle(0);
        rd(8'h20, 0, 4'h0, 0);      // flagged read
        idle(1);                    // clear meets the error: set wins
        idle(0);
        idle(1);
        idle(0);
        cur_req = "R9";
        for (int fl = 0; fl < 10; fl++)
            for (int fo = 0; fo < 2; fo++) rd(8'h10, 1, 4'(fl), fo[0]);
        idle(0);
        idle(1);
        idle(0);
    endtask

    initial begin
        logic [15:0] sd;
        idle(0);
        run_cfg(16'h0);             // R2: zero seed behaves as seed 1
        for (int c = 0; c < 16; c++) begin
            sd = 16'h0;
            for (int s = 1; s < 65536; s++) begin
                if (cfg_of(16'(s)) == 4'(c)) begin
                    sd = 16'(s);
                    break;
                end
            end
            if (sd != 16'h0) run_cfg(sd);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end
endmodule